// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog that guards a processor against hangs. A 32-bit down-counter, fed from a programmable load value, runs once software sets the run-enable bit. When the count reaches zero for the first time the block raises an interrupt and reloads the counter. If software services the interrupt, the sequence starts again. If the counter reaches zero a second time while the interrupt is still pending, and the reset-enable bit is set, the block requests a system reset. The request is held for a fixed number of cycles, and the block then returns to its power-on state.

Software reaches the block through a simple word-addressed register port. The port has a write strobe, a 3-bit word address and 32-bit write data, and read data comes back combinationally. The registers are: load value (offset 0, read/write), current count (offset 1, read-only), control (offset 2: bit 0 run-enable, bit 1 reset-enable), interrupt clear (offset 3, write any value), raw status (offset 4, bit 0 = interrupt pending) and masked status (offset 5, bit 0 = interrupt output).

The state machine has four states. IDLE means not running. ARMED means running with no interrupt pending. PENDING means the first timeout has happened and the interrupt is asserted. RESETTING means the reset request is being driven. The transitions are as follows. IDLE goes to ARMED when run-enable is set, or straight to PENDING if a timeout already occurs in that cycle. ARMED goes to PENDING on a timeout. PENDING goes back to ARMED on an interrupt-clear write. PENDING goes to RESETTING on a timeout while reset-enable is set. With reset-enable clear, PENDING stays in PENDING on a timeout and only reloads. RESETTING goes to IDLE after the fixed pulse, and that transition wipes every register back to its power-on value. An interrupt-clear write takes priority over a timeout in the same cycle.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset, the load value and the count read 0xFFFFFFFF, control reads 0, raw status reads 0, and both irq and sys_rst_req are low.
- R2: While run-enable (control bit 0) is clear, the count does not change.
- R3: A write to the load register (offset 0) stores the value and loads it into the counter on the same clock edge.
- R4: While running, the count at offset 1 decreases by one on every clock edge.
- R5: When the count is zero while running, the next edge raises irq and reloads the counter from the load value. Timeouts are therefore load+1 cycles apart.
- R6: Raw status bit 0 (offset 4) reads 1 exactly while the interrupt is pending.
- R7: Any write to offset 3 drops irq and reloads the counter. It takes priority over a timeout in the same cycle, so a cleared interrupt never leads to a reset.
- R8: With reset-enable (control bit 1) clear, timeouts while the interrupt is pending only reload the counter, and sys_rst_req stays low.
- R9: With reset-enable set, a timeout while the interrupt is pending raises sys_rst_req on the next edge.
- R10: sys_rst_req stays high for exactly 16 cycles. After that, every register holds its power-on value again.
- R11: Once set, run-enable cannot be cleared by a write. Only reset or a watchdog reset clears it.
- R12: With a load value of 0, the first clock edge after run-enable is set produces a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Word address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| irq | output | 1 | Interrupt after the first timeout |
| sys_rst_req | output | 1 | System reset request after the second timeout |

## Verification
The assertions assume that wr_en, addr and wdata change only away from the rising edge and are never X after reset. They also assume that a write is a single-cycle strobe carrying one address. The bench drives every input on the falling edge and lowers wr_en after one cycle. It samples outputs one nanosecond after a falling edge, so each write and each wait step covers exactly one rising edge. All expected counts and delays are derived from that one-edge-per-step rule.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_ARMED     = 2'd1,
        ST_PENDING   = 2'd2,
        ST_RESETTING = 2'd3
    } wd_state_e;

    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] OFS_LOAD   = 3'd0;
    localparam logic [REG_AW-1:0] OFS_COUNT  = 3'd1;
    localparam logic [REG_AW-1:0] OFS_CTRL   = 3'd2;
    localparam logic [REG_AW-1:0] OFS_CLEAR  = 3'd3;
    localparam logic [REG_AW-1:0] OFS_RAW    = 3'd4;
    localparam logic [REG_AW-1:0] OFS_MASKED = 3'd5;

    localparam int CTRL_RUN_BIT = 0;
    localparam int CTRL_RST_BIT = 1;

endpackage

// File: rtl/wdog_regif.sv
module wdog_regif
    import wdog_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = REG_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wipe,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] count,
    input  logic          pending,
    input  logic          irq_out,
    output logic [DW-1:0] load_val,
    output logic [DW-1:0] reload_val,
    output logic          run_en,
    output logic          rst_en,
    output logic          load_wr,
    output logic          clr_wr,
    output logic [DW-1:0] rdata
);

    localparam logic [DW-1:0] LOAD_INIT = '1;

    logic ctrl_wr;

    always_comb begin
        load_wr = wr_en && (addr == OFS_LOAD);
        ctrl_wr = wr_en && (addr == OFS_CTRL);
        clr_wr  = wr_en && (addr == OFS_CLEAR);
    end

    // The value the counter takes on a reload: a fresh load write wins.
    always_comb begin
        reload_val = load_wr ? wdata : load_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_val <= LOAD_INIT;
        end else if (wipe) begin
            load_val <= LOAD_INIT;
        end else if (load_wr) begin
            load_val <= wdata;
        end
    end

    // Run-enable only accumulates; reset-enable follows the written value.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_en <= 1'b0;
            rst_en <= 1'b0;
        end else if (wipe) begin
            run_en <= 1'b0;
            rst_en <= 1'b0;
        end else if (ctrl_wr) begin
            run_en <= run_en | wdata[CTRL_RUN_BIT];
            rst_en <= wdata[CTRL_RST_BIT];
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            OFS_LOAD:   rdata = load_val;
            OFS_COUNT:  rdata = count;
            OFS_CTRL: begin
                rdata[CTRL_RUN_BIT] = run_en;
                rdata[CTRL_RST_BIT] = rst_en;
            end
            OFS_RAW:    rdata[0] = pending;
            OFS_MASKED: rdata[0] = irq_out;
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wipe,
    input  logic          run,
    input  logic          reload,
    input  logic [DW-1:0] reload_val,
    output logic [DW-1:0] count,
    output logic          timeout
);

    localparam logic [DW-1:0] COUNT_INIT = '1;
    localparam logic [DW-1:0] ONE        = {{(DW-1){1'b0}}, 1'b1};

    logic at_zero;

    always_comb begin
        at_zero = (count == '0);
        timeout = run && at_zero;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= COUNT_INIT;
        end else if (wipe) begin
            count <= COUNT_INIT;
        end else if (reload || timeout) begin
            count <= reload_val;
        end else if (run) begin
            count <= count - ONE;
        end
    end

endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
#(
    parameter int RST_CYCLES = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      run_en,
    input  logic      rst_en,
    input  logic      timeout,
    input  logic      clr_wr,
    output wd_state_e state,
    output logic      pending,
    output logic      sys_rst_req,
    output logic      wipe,
    output logic      frozen
);

    localparam int PW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
    localparam logic [PW-1:0] PULSE_LAST = PW'(RST_CYCLES - 1);

    wd_state_e     state_nx;
    logic [PW-1:0] pulse_cnt;
    logic          pulse_done;

    always_comb begin
        pulse_done = (pulse_cnt == PULSE_LAST);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (run_en) begin
                    state_nx = (timeout && !clr_wr) ? ST_PENDING : ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (timeout && !clr_wr) begin
                    state_nx = ST_PENDING;
                end
            end
            ST_PENDING: begin
                if (clr_wr) begin
                    state_nx = ST_ARMED;
                end else if (timeout && rst_en) begin
                    state_nx = ST_RESETTING;
                end
            end
            ST_RESETTING: begin
                if (pulse_done) begin
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Reset pulse length counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_cnt <= '0;
        end else if (state == ST_RESETTING) begin
            pulse_cnt <= pulse_done ? '0 : pulse_cnt + 1'b1;
        end else begin
            pulse_cnt <= '0;
        end
    end

    // Outputs
    always_comb begin
        pending     = 1'b0;
        sys_rst_req = 1'b0;
        frozen      = 1'b0;
        wipe        = 1'b0;
        unique case (state)
            ST_IDLE:      ;
            ST_ARMED:     ;
            ST_PENDING:   pending = 1'b1;
            ST_RESETTING: begin
                sys_rst_req = 1'b1;
                frozen      = 1'b1;
                wipe        = pulse_done;
            end
            default:      ;
        endcase
    end

endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
    import wdog_pkg::*;
#(
    parameter int DW         = 32,
    parameter int AW         = REG_AW,
    parameter int RST_CYCLES = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          irq,
    output logic          sys_rst_req
);

    wd_state_e     state;
    logic [DW-1:0] count;
    logic [DW-1:0] load_val;
    logic [DW-1:0] reload_val;
    logic          run_en;
    logic          rst_en;
    logic          load_wr;
    logic          clr_wr;
    logic          timeout;
    logic          pending;
    logic          wipe;
    logic          frozen;
    logic          run;

    always_comb begin
        run = run_en && !frozen;
        irq = pending && run_en;
    end

    wdog_regif #(.DW(DW), .AW(AW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wipe       (wipe),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .count      (count),
        .pending    (pending),
        .irq_out    (irq),
        .load_val   (load_val),
        .reload_val (reload_val),
        .run_en     (run_en),
        .rst_en     (rst_en),
        .load_wr    (load_wr),
        .clr_wr     (clr_wr),
        .rdata      (rdata)
    );

    wdog_counter #(.DW(DW)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .wipe       (wipe),
        .run        (run),
        .reload     (load_wr | clr_wr),
        .reload_val (reload_val),
        .count      (count),
        .timeout    (timeout)
    );

    wdog_fsm #(.RST_CYCLES(RST_CYCLES)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_en      (run_en),
        .rst_en      (rst_en),
        .timeout     (timeout),
        .clr_wr      (clr_wr),
        .state       (state),
        .pending     (pending),
        .sys_rst_req (sys_rst_req),
        .wipe        (wipe),
        .frozen      (frozen)
    );

endmodule

// File: rtl/wdog_two_stage_chk.sv
module wdog_two_stage_chk
    import wdog_pkg::*;
#(
    parameter int DW         = 32,
    parameter int RST_CYCLES = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          irq,
    input logic          sys_rst_req,
    input wd_state_e     state,
    input logic [DW-1:0] count,
    input logic          run_en,
    input logic          rst_en,
    input logic          load_wr,
    input logic          clr_wr,
    input logic          wipe
);

    localparam int HW = $clog2(RST_CYCLES + 1);

    logic [HW-1:0] hi_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_len <= '0;
        end else if (sys_rst_req) begin
            hi_len <= hi_len + 1'b1;
        end else begin
            hi_len <= '0;
        end
    end

    // R2
    hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(run_en) && !$past(load_wr) && !$past(clr_wr) && !$past(wipe)) |-> $stable(count));

    // R5
    irq_after_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(count) == '0 && $past(run_en)));

    // R7
    clear_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_wr) |-> !irq);

    // R9
    reset_from_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_req) |-> ($past(state) == ST_PENDING && $past(rst_en) && !$past(clr_wr)));

    // R10
    pulse_not_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |-> (hi_len < HW'(RST_CYCLES)));

    // R10
    pulse_full_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst_req) |-> (hi_len == HW'(RST_CYCLES)));

    // R11
    run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run_en) && !$past(wipe)) |-> run_en);

endmodule

bind wdog_two_stage wdog_two_stage_chk #(.DW(DW), .RST_CYCLES(RST_CYCLES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq         (irq),
    .sys_rst_req (sys_rst_req),
    .state       (state),
    .count       (count),
    .run_en      (run_en),
    .rst_en      (rst_en),
    .load_wr     (load_wr),
    .clr_wr      (clr_wr),
    .wipe        (wipe)
);

// File: tb/wdog_two_stage_test.sv
`timescale 1ns/1ps
module wdog_two_stage_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic        irq;
    logic        sys_rst_req;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #10 clk = ~clk;

    wdog_two_stage uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .addr        (addr),
        .wdata       (wdata),
        .rdata       (rdata),
        .irq         (irq),
        .sys_rst_req (sys_rst_req)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            n_fails = n_fails + 1;
            $display("FAIL watchdog (all R) actual=%0d cycles expected<20000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks = n_checks + 1;
        if (act !== exp) begin
            n_fails = n_fails + 1;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        wr_en = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        apply_reset();
        rd(3'd0, v); check("R1 load", v, 32'hFFFF_FFFF);
        rd(3'd1, v); check("R1 count", v, 32'hFFFF_FFFF);
        rd(3'd2, v); check("R1 ctrl", v, 32'd0);
        rd(3'd4, v); check("R1 raw", v, 32'd0);
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 rst", {31'd0, sys_rst_req}, 32'd0);
    endtask

    task automatic t_load_and_hold();
        logic [31:0] v;
        wr(3'd0, 32'd10);
        rd(3'd1, v); check("R3 load reloads count", v, 32'd10);
        step(5);
        rd(3'd1, v); check("R2 count holds while stopped", v, 32'd10);
    endtask

    task automatic t_first_timeout();
        logic [31:0] v;
        wr(3'd2, 32'd1);
        rd(3'd1, v); check("R4 count at enable", v, 32'd10);
        step(3);
        rd(3'd1, v); check("R4 count decrements", v, 32'd7);
        step(7);
        check("R5 no irq before zero passes", {31'd0, irq}, 32'd0);
        rd(3'd4, v); check("R6 raw status idle", v, 32'd0);
        step(1);
        check("R5 irq raised", {31'd0, irq}, 32'd1);
        rd(3'd1, v); check("R5 reload after timeout", v, 32'd10);
        rd(3'd4, v); check("R6 raw status pending", v, 32'd1);
    endtask

    task automatic t_clear();
        logic [31:0] v;
        wr(3'd3, 32'd0);
        check("R7 clear drops irq", {31'd0, irq}, 32'd0);
        rd(3'd1, v); check("R7 clear reloads", v, 32'd10);
        rd(3'd4, v); check("R6 raw status after clear", v, 32'd0);
    endtask

    task automatic t_sticky();
        logic [31:0] v;
        wr(3'd2, 32'd0);
        rd(3'd2, v); check("R11 run bit sticky", v, 32'd1);
        step(2);
        rd(3'd1, v); check("R11 counter still runs", v, 32'd7);
    endtask

    task automatic t_no_reset_when_disabled();
        int saw_rst = 0;
        for (int i = 0; i < 24; i++) begin
            step(1);
            if (sys_rst_req) saw_rst = 1;
        end
        check("R8 no reset with reset disabled", saw_rst, 0);
        check("R8 irq still pending", {31'd0, irq}, 32'd1);
    endtask

    task automatic t_reset_pulse();
        logic [31:0] v;
        int n = 0;
        int m = 0;
        wr(3'd3, 32'd0);
        wr(3'd2, 32'd3);
        while (!sys_rst_req && n < 100) begin
            step(1);
            n++;
        end
        check("R9 reset after second timeout", n, 21);
        check("R9 irq dropped in reset", {31'd0, irq}, 32'd0);
        while (sys_rst_req && m < 100) begin
            step(1);
            m++;
        end
        check("R10 reset pulse length", m, 16);
        rd(3'd2, v); check("R10 ctrl wiped", v, 32'd0);
        rd(3'd0, v); check("R10 load wiped", v, 32'hFFFF_FFFF);
        rd(3'd1, v); check("R10 count wiped", v, 32'hFFFF_FFFF);
        check("R10 irq low after wipe", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_clear_prevents_reset();
        int saw_rst = 0;
        apply_reset();
        wr(3'd0, 32'd4);
        wr(3'd2, 32'd3);
        step(5);
        check("R5 short period timeout", {31'd0, irq}, 32'd1);
        wr(3'd3, 32'd0);
        for (int i = 0; i < 8; i++) begin
            step(1);
            if (sys_rst_req) saw_rst = 1;
        end
        check("R7 serviced irq gives no reset", saw_rst, 0);
        check("R7 next first timeout", {31'd0, irq}, 32'd1);
    endtask

    task automatic t_zero_load();
        logic [31:0] v;
        apply_reset();
        wr(3'd0, 32'd0);
        wr(3'd2, 32'd1);
        check("R12 no irq at enable edge", {31'd0, irq}, 32'd0);
        step(1);
        check("R12 timeout on next edge", {31'd0, irq}, 32'd1);
        rd(3'd1, v); check("R12 count stays zero", v, 32'd0);
    endtask

    initial begin
        t_reset_state();
        t_load_and_hold();
        t_first_timeout();
        t_clear();
        t_sticky();
        t_no_reset_when_disabled();
        t_reset_pulse();
        t_clear_prevents_reset();
        t_zero_load();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule